// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that first warns and then resets. Once enabled, it counts down a selectable timeout. The clock is divided by a selectable prescaler before it reaches the counter. At the first expiry the block sets an interrupt flag and starts a short fixed grace window. The interrupt output follows that flag when interrupts are enabled. If software does not service the watchdog before the grace window also runs out, and reset is enabled, the block latches a reset flag and sends a one-cycle pulse to the system reset logic.

All control goes through one 32-bit control word. It is written through a write strobe and always visible on a read-back port. Software keeps the watchdog alive by writing a self-clearing restart bit. Both status flags are cleared by writing 1 to them. The reset flag is kept through a core reset, so software can find out after reboot why the reset happened. Only a power-on reset clears it.

Top module: `wdog_two_stage`

## Requirements
- R1: When core reset or power-on reset is low, the control word becomes 0x400, with the divider select at 1 and all other fields 0. The only exception is the reset flag, which follows R2. After reset, irq_o and sys_rst_o are low, and the counter holds the timeout for select 0.
- R2: The reset flag (bit 2) keeps its value through a core reset (rst_n low). It is cleared only by power-on reset (por_n low).
- R3: Divider select sits in bits 11:10. Values 0 to 3 pick a divide ratio of 2^DIV0_LOG2 to 2^DIV3_LOG2. The defaults give 1, 256, 2048 and 65536.
- R4: Timeout select sits in bits 5:4, and the timeout is 2^(BASE_EXP + 2*select) prescaled cycles. With enable (bit 7) set, the first expiry happens exactly timeout × divide clock edges after the write edge that restarts or enables the count.
- R5: On an expiry while the interrupt flag (bit 3) is clear, the block sets that flag. irq_o is high exactly while the interrupt flag and interrupt enable (bit 6) are both set.
- R6: The first expiry reloads the counter with GRACE prescaled cycles (default 1024). The next expiry comes GRACE × divide edges later.
- R7: On an expiry while the interrupt flag is set, two cases apply. If reset enable (bit 1) is set, the block sets the reset flag and drives sys_rst_o high for exactly one cycle. If reset enable is clear, nothing changes.
- R8: Writing 1 to bit 3 or bit 2 clears that flag. Writing 0 to either bit leaves that flag unchanged.
- R9: Writing 1 to bit 0 reloads the full timeout, using the timeout select in the same write, and restarts the prescaler. Bit 0 always reads back as 0.
- R10: Clearing enable without a restart freezes the counter and the prescaler. Setting enable again resumes the count from the frozen value.
- R11: While enable is clear, no expiry takes place, and the flags and outputs do not change except through writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and reference tick |
| por_n | input | 1 | Synchronous power-on reset, active low; clears everything |
| rst_n | input | 1 | Synchronous core reset, active low; keeps the reset flag |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| ctrl_o | output | 32 | Control word read-back |
| irq_o | output | 1 | Watchdog interrupt, level |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is the second expiry, because it takes a full timeout, then the whole grace window, with no software action between them. With the default dividers this runs to millions of cycles. The bench therefore builds the block with a small base exponent, a short grace window and divide ratios of 1, 2, 4 and 8. It then walks a table of divider, timeout and enable settings, and counts the exact edge at which each flag and the reset pulse should appear. The sticky flag is reached by letting the reset pulse fire and then applying a core reset followed by a power-on reset. Pause and resume are reached by clearing enable partway through a count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Control word bit positions (software-visible layout)
    localparam int unsigned B_RESTART = 0;
    localparam int unsigned B_RST_EN  = 1;
    localparam int unsigned B_RFLAG   = 2;
    localparam int unsigned B_IFLAG   = 3;
    localparam int unsigned B_TSEL_LO = 4;
    localparam int unsigned B_IRQ_EN  = 6;
    localparam int unsigned B_ENABLE  = 7;
    localparam int unsigned B_DSEL_LO = 10;

    // Writable and flag state held by the watchdog (reset flag kept apart)
    typedef struct packed {
        logic [1:0] dsel;
        logic       enable;
        logic       irq_en;
        logic [1:0] tsel;
        logic       iflag;
        logic       rst_en;
    } wd_ctrl_t;

    localparam wd_ctrl_t CTRL_RESET = '{dsel: 2'd1, default: '0};

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV0_LOG2 = 0,
    parameter int DIV1_LOG2 = 8,
    parameter int DIV2_LOG2 = 11,
    parameter int DIV3_LOG2 = 16
) (
    input  logic       clk,
    input  logic       core_rst,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);

    localparam int MAX01  = (DIV0_LOG2 > DIV1_LOG2) ? DIV0_LOG2 : DIV1_LOG2;
    localparam int MAX23  = (DIV2_LOG2 > DIV3_LOG2) ? DIV2_LOG2 : DIV3_LOG2;
    localparam int MAXLOG = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int PS_W   = MAXLOG + 1;

    logic [PS_W-1:0] lim [4];
    logic [PS_W-1:0] div_m1;
    logic [PS_W-1:0] cnt_d, cnt_q;

    // One terminal-count value per select code
    for (genvar g = 0; g < 4; g++) begin : g_lim
        localparam int LG = (g == 0) ? DIV0_LOG2 : (g == 1) ? DIV1_LOG2 :
                            (g == 2) ? DIV2_LOG2 : DIV3_LOG2;
        assign lim[g] = PS_W'((64'd1 << LG) - 64'd1);
    end

    always_comb begin
        div_m1 = lim[sel];
        tick   = run && (cnt_q >= div_m1);
        cnt_d  = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else if (run)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (core_rst) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end

    // R10
    ps_frozen_chk: assert property (@(posedge clk) disable iff (core_rst)
        (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             core_rst,
    input  logic [CNT_W-1:0] rst_val,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && (cnt_q == CNT_W'(1));
        cnt_d  = cnt_q;
        if (load)                          cnt_d = load_val;
        else if (tick && (cnt_q != '0))    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (core_rst) cnt_q <= rst_val;
        else          cnt_q <= cnt_d;
    end

    // R9
    load_taken_chk: assert property (@(posedge clk) disable iff (core_rst)
        load |=> (cnt_q == $past(load_val)));

    // R7
    spent_hold_chk: assert property (@(posedge clk) disable iff (core_rst)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int BASE_EXP  = 14,
    parameter int GRACE     = 1024,
    parameter int DIV0_LOG2 = 0,
    parameter int DIV1_LOG2 = 8,
    parameter int DIV2_LOG2 = 11,
    parameter int DIV3_LOG2 = 16
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_o,
    output logic        irq_o,
    output logic        sys_rst_o
);

    localparam int TMO_W = BASE_EXP + 7;
    localparam int GR_W  = $clog2(GRACE + 1);
    localparam int CNT_W = (TMO_W > GR_W) ? TMO_W : GR_W;

    function automatic logic [CNT_W-1:0] timeout_of(input logic [1:0] s);
        return CNT_W'(1) << (BASE_EXP + 2 * int'(s));
    endfunction

    wd_ctrl_t         ctrl_d, ctrl_q;
    logic             rflag_d, rflag_q;
    logic             pulse_d, pulse_q;
    logic             core_rst;
    logic             restart_wr;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             tick, expire;
    logic             unused_wr_bits;

    assign core_rst       = !rst_n || !por_n;
    assign restart_wr     = wr_en && wr_data[B_RESTART];
    assign unused_wr_bits = ^{wr_data[31:12], wr_data[9:8]};

    always_comb begin
        ctrl_d   = ctrl_q;
        rflag_d  = rflag_q;
        pulse_d  = 1'b0;
        load     = 1'b0;
        load_val = timeout_of(wr_data[B_TSEL_LO +: 2]);
        if (wr_en) begin
            ctrl_d.dsel   = wr_data[B_DSEL_LO +: 2];
            ctrl_d.enable = wr_data[B_ENABLE];
            ctrl_d.irq_en = wr_data[B_IRQ_EN];
            ctrl_d.tsel   = wr_data[B_TSEL_LO +: 2];
            ctrl_d.rst_en = wr_data[B_RST_EN];
            if (wr_data[B_IFLAG]) ctrl_d.iflag = 1'b0;
            if (wr_data[B_RFLAG]) rflag_d      = 1'b0;
            if (restart_wr)       load         = 1'b1;
        end
        if (expire && !restart_wr) begin
            if (!ctrl_q.iflag) begin
                ctrl_d.iflag = 1'b1;
                load         = 1'b1;
                load_val     = CNT_W'(GRACE);
            end else if (ctrl_q.rst_en) begin
                rflag_d = 1'b1;
                pulse_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            ctrl_q  <= CTRL_RESET;
            pulse_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            pulse_q <= pulse_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n)      rflag_q <= 1'b0;
        else if (rst_n)  rflag_q <= rflag_d;
    end

    wdog_prescaler #(
        .DIV0_LOG2(DIV0_LOG2), .DIV1_LOG2(DIV1_LOG2),
        .DIV2_LOG2(DIV2_LOG2), .DIV3_LOG2(DIV3_LOG2)
    ) u_ps (
        .clk(clk), .core_rst(core_rst), .run(ctrl_q.enable),
        .clr(restart_wr), .sel(ctrl_q.dsel), .tick(tick)
    );

    wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .core_rst(core_rst), .rst_val(timeout_of(2'd0)),
        .tick(tick), .load(load), .load_val(load_val), .expire(expire)
    );

    assign ctrl_o = {20'd0, ctrl_q.dsel, 2'd0, ctrl_q.enable, ctrl_q.irq_en,
                     ctrl_q.tsel, ctrl_q.iflag, rflag_q, ctrl_q.rst_en, 1'b0};
    assign irq_o     = ctrl_q.iflag && ctrl_q.irq_en;
    assign sys_rst_o = pulse_q;

    // R7
    one_pulse_chk: assert property (@(posedge clk) disable iff (core_rst)
        sys_rst_o |=> !sys_rst_o);

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (core_rst)
        sys_rst_o |-> $past(ctrl_q.rst_en && ctrl_q.iflag && ctrl_q.enable));

    // R5
    iflag_source_chk: assert property (@(posedge clk) disable iff (core_rst)
        $rose(ctrl_q.iflag) |-> $past(expire));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (core_rst)
        !ctrl_q.enable |-> !expire);

endmodule

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;

    localparam int GR = 8;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_o;
    logic        irq_o, sys_rst_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wdog_two_stage #(
        .BASE_EXP(4), .GRACE(GR),
        .DIV0_LOG2(0), .DIV1_LOG2(1), .DIV2_LOG2(2), .DIV3_LOG2(3)
    ) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .ctrl_o(ctrl_o), .irq_o(irq_o),
        .sys_rst_o(sys_rst_o)
    );

    // {dsel[1:0], tsel[1:0], irq_en, rst_en}
    localparam logic [5:0] VEC [5] = '{
        6'b00_00_1_1,
        6'b01_01_0_1,
        6'b10_00_1_0,
        6'b11_10_1_1,
        6'b00_11_0_0
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        edges(3);
        @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ctrl", ctrl_o, 32'h400);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 rst", {31'd0, sys_rst_o}, 0);

        // R11 disabled: no expiry over many cycles
        edges(100);
        chk("R11 idle", ctrl_o, 32'h400);

        // R4 enable without restart after reset: 16 x 2 edges
        wr(32'h480);
        edges(31);
        chk("R4 early", {31'd0, ctrl_o[3]}, 0);
        edges(1);
        chk("R4 expiry", {31'd0, ctrl_o[3]}, 1);
        // R8 write 0 keeps flag, write 1 clears
        wr(32'h480);
        chk("R8 keep", {31'd0, ctrl_o[3]}, 1);
        wr(32'h408);
        chk("R8 clear", ctrl_o, 32'h400);

        // Table of divider / timeout / enable settings
        for (int v = 0; v < 5; v++) begin
            logic [1:0] ds, ts;
            logic ie, re;
            int t, d;
            {ds, ts, ie, re} = VEC[v];
            t = 1 << (4 + 2 * int'(ts));
            d = 1 << int'(ds);
            wr({20'd0, ds, 2'd0, 1'b1, ie, ts, 1'b1, 1'b1, re, 1'b1});
            // R9 restart bit reads 0
            chk("R9 readback", {31'd0, ctrl_o[0]}, 0);
            edges(t * d - 1);
            chk("R3 R4 before", {31'd0, ctrl_o[3]}, 0);
            edges(1);
            chk("R5 iflag", {31'd0, ctrl_o[3]}, 1);
            chk("R5 irq", {31'd0, irq_o}, {31'd0, ie});
            edges(GR * d - 1);
            chk("R6 grace quiet", {31'd0, sys_rst_o}, 0);
            edges(1);
            chk("R7 pulse", {31'd0, sys_rst_o}, {31'd0, re});
            chk("R7 rflag", {31'd0, ctrl_o[2]}, {31'd0, re});
            edges(1);
            chk("R7 one cycle", {31'd0, sys_rst_o}, 0);
            wr(32'h0C);
            chk("R8 both cleared", ctrl_o, 32'h0);
            chk("R8 irq low", {31'd0, irq_o}, 0);
        end

        // R10 pause and resume (divide 1, timeout 16)
        wr(32'h81);
        edges(5);
        wr(32'h00);
        edges(20);
        chk("R10 paused", {31'd0, ctrl_o[3]}, 0);
        wr(32'h80);
        edges(9);
        chk("R10 resumed early", {31'd0, ctrl_o[3]}, 0);
        edges(1);
        chk("R10 resumed expiry", {31'd0, ctrl_o[3]}, 1);
        wr(32'h08);

        // R9 restart mid-count reloads the full timeout
        wr(32'h81);
        edges(10);
        wr(32'h81);
        edges(15);
        chk("R9 reload early", {31'd0, ctrl_o[3]}, 0);
        edges(1);
        chk("R9 reload expiry", {31'd0, ctrl_o[3]}, 1);
        wr(32'h08);

        // R2 sticky reset flag
        wr(32'h83);
        edges(16 + GR);
        chk("R2 rflag set", {31'd0, ctrl_o[2]}, 1);
        @(negedge clk);
        rst_n = 1'b0;
        edges(2);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 survives core reset", ctrl_o, 32'h404);
        chk("R1 irq after core reset", {31'd0, irq_o}, 0);
        @(negedge clk);
        por_n = 1'b0;
        edges(2);
        @(negedge clk);
        por_n = 1'b1;
        #1;
        chk("R2 power-on clears", ctrl_o, 32'h400);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule